// File: doc/BRIEF.md
# Staged Memory Access Sequencer

This block sits between a processor core and its memory and performs every access through two internal staging registers: an address register and a data register. The core posts a single request (read or write, with an address and, for writes, a data word) and gets back a one-cycle completion pulse. For a read, the fetched word is presented together with that pulse.

On the memory side the block drives an address, a write data word and separate read and write strobes. It then holds the strobe until the memory answers with a ready signal, however many cycles that takes. For a write the data word is staged first and the address second, and the write strobe comes only after both are in place. For a read the address is staged first, then the read strobe is raised, and the data register captures the memory's word only in the cycle the memory reports ready. The two staging registers have no access path of their own. They are seen only through the memory-side outputs and the read data output.

Top module: `mem_access_seq`

## Requirements
- R1: After reset `busy`, `done`, `memRd` and `memWr` are all low.
- R2: A write request is accepted at the rising edge where `reqValid` is high while idle. The cycle after that edge is a staging cycle with both strobes low and `busy` high. From the next cycle `memWr` is high, with `memAddr` equal to the request address and `memWdata` equal to the request data.
- R3: A read request follows the same timing as R2, with `memRd` high instead and `memAddr` equal to the request address.
- R4: The strobe, `memAddr` and `memWdata` stay unchanged until `memReady` is sampled high. If memory answers in the L-th strobe cycle (L ≥ 1), then `done` is high in the cycle after the (L+1)-th rising edge following the accepting edge, and the strobe is low in that cycle.
- R5: For a read, `rdData` shows the value of `memRdata` sampled at the ready edge during the `done` cycle. It keeps that value until a later request is accepted.
- R6: `done` is high for exactly one cycle per access, and `busy` is low in that cycle.
- R7: A `reqValid` pulse while `busy` is high is ignored. The running access keeps its address, data and timing, and memory at the intruding address stays unchanged.
- R8: `memRd` and `memWr` are never high in the same cycle.
- R9: `memReady` while no strobe is active has no effect: `done` and `busy` stay low.
- R10: Writing 0x007E to address 0x2005 and then reading 0x2005 returns 0x007E. A read of 0x2010 returns the word stored there (0x00C4 in the bench).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe from the core |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqData | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| rdData | output | DATA_W | Read result, valid with `done` |
| memAddr | output | ADDR_W | Memory address (address register) |
| memWdata | output | DATA_W | Memory write data (data register) |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memReady | input | 1 | Memory response |
| memRdata | input | DATA_W | Memory read data |

## Verification
Each access has a fixed cycle plan. The first cycle after the accepting edge is a staging cycle with no strobe. Strobe cycles run from the second edge up to and including the L-th strobe cycle. `done`, along with any read data, is due in the cycle after edge L+1. The bench's memory model answers after a latency it sets (1 to 8), so the bench knows L in advance. It samples on the falling edge after each rising edge and checks the expected strobe, address, data or completion against that plan. A late or early `done` therefore fails at the exact cycle.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_STROBE,
    ST_WAIT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdLoad;    // capture request address into holding register
    logic mdrFromReq;  // stage write data into data register
    logic marLoad;     // move held address into address register
    logic mdrFromMem;  // capture memory read word into data register
  } dpCtrl_t;

endpackage

// File: rtl/memseq_ctrl.sv
module memseq_ctrl
  import memseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    memReady,
  output dpCtrl_t dpCtrl,
  output logic    memRd,
  output logic    memWr,
  output logic    done,
  output logic    busy
);

  seqState_t state, stateNext;
  logic      opWrite;
  logic      accessing;
  logic      accept;

  assign accessing = (state == ST_STROBE) || (state == ST_WAIT);
  assign accept    = (state == ST_IDLE) && reqValid;

  always_comb begin
    stateNext = state;
    dpCtrl    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          dpCtrl.holdLoad   = 1'b1;
          dpCtrl.mdrFromReq = reqWrite;
          stateNext         = ST_LOAD;
        end
      end
      ST_LOAD: begin
        dpCtrl.marLoad = 1'b1;
        stateNext      = ST_STROBE;
      end
      ST_STROBE, ST_WAIT: begin
        if (memReady) begin
          dpCtrl.mdrFromMem = !opWrite;
          stateNext         = ST_IDLE;
        end else begin
          stateNext = ST_WAIT;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= accessing && memReady;
      if (accept) opWrite <= reqWrite;
    end
  end

  assign memRd = accessing && !opWrite;
  assign memWr = accessing && opWrite;
  assign busy  = (state != ST_IDLE);

  // strobe phase is entered only from the staging cycle
  assert_strobe_after_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE) |-> ($past(state) == ST_LOAD));

  // a request seen mid-access does not alter the running operation
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && !(accessing && memReady)) |=> ($stable(opWrite) && busy));

endmodule

// File: rtl/memseq_datapath.sv
module memseq_datapath
  import memseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] marQ,
  output logic [DATA_W-1:0] mdrQ
);

  logic [ADDR_W-1:0] holdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr <= '0;
      marQ     <= '0;
      mdrQ     <= '0;
    end else begin
      if (dpCtrl.holdLoad)   holdAddr <= reqAddr;
      if (dpCtrl.marLoad)    marQ     <= holdAddr;
      if (dpCtrl.mdrFromReq) mdrQ     <= reqData;
      else if (dpCtrl.mdrFromMem) mdrQ <= memRdata;
    end
  end

  // the two data-register sources are never selected together
  assert_mdr_single_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtrl.mdrFromReq && dpCtrl.mdrFromMem));

endmodule

// File: rtl/mem_access_seq.sv
module mem_access_seq
  import memseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRd,
  output logic              memWr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);

  dpCtrl_t           dpCtrl;
  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] mdrQ;

  memseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .memReady (memReady),
    .dpCtrl   (dpCtrl),
    .memRd    (memRd),
    .memWr    (memWr),
    .done     (done),
    .busy     (busy)
  );

  memseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .memRdata (memRdata),
    .marQ     (marQ),
    .mdrQ     (mdrQ)
  );

  assign memAddr  = marQ;
  assign memWdata = mdrQ;
  assign rdData   = mdrQ;

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((memRd || memWr) && !memReady) |=>
      ((memRd || memWr) && $stable(memAddr) && $stable(memWdata)));

  assert_done_after_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(memReady) && !memRd && !memWr));

  assert_stray_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!memRd && !memWr) |=> !done);

endmodule

// File: tb/mem_access_seq_bench.sv
module mem_access_seq_bench;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          done, busy, memRd, memWr, memReady;
  logic [DW-1:0] rdData, memWdata, memRdata;
  logic [AW-1:0] memAddr;

  int nChecks = 0;
  int nErrors = 0;

  // memory model state
  logic [DW-1:0] store [int];
  int            latency = 1;
  int            waitCnt = 0;
  logic          strayReady = 1'b0;

  always #10 clk = ~clk;

  mem_access_seq #(.ADDR_W(AW), .DATA_W(DW)) u_mem_access_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .done(done), .busy(busy),
    .rdData(rdData), .memAddr(memAddr), .memWdata(memWdata),
    .memRd(memRd), .memWr(memWr), .memReady(memReady), .memRdata(memRdata)
  );

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    if (store.exists(int'(a))) return store[int'(a)];
    return a ^ 16'h6C39;
  endfunction

  assign memReady = ((memRd || memWr) && (waitCnt == latency - 1)) || strayReady;
  assign memRdata = peek(memAddr);

  always @(posedge clk) begin
    if (memRd || memWr) begin
      if (memReady) begin
        waitCnt <= 0;
        if (memWr) store[int'(memAddr)] = memWdata;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      waitCnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  // R8: strobes never overlap, sampled every cycle
  always @(negedge clk) if (rstN) chk(!(memRd && memWr), "R8 strobe overlap", {memRd, memWr}, 2'b00);

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int lat, input bit intrude, input logic [DW-1:0] expRd,
                        output logic [DW-1:0] got);
    string tg;
    tg = wr ? "R2" : "R3";
    latency = lat;
    got = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqData = '0;
    chk(busy && !memRd && !memWr && !done, {tg, " staging cycle"}, {busy, memRd, memWr, done}, 4'b1000);
    for (int k = 1; k <= lat + 1; k++) begin
      if (intrude && k == 1) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h3000; reqData = 16'hBEEF;
      end
      @(posedge clk);
      @(negedge clk);
      reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqData = '0;
      if (k <= lat) begin
        chk(wr ? (memWr && !memRd) : (memRd && !memWr), {tg, " strobe"}, {memRd, memWr}, {!wr, wr});
        chk(memAddr == a, intrude ? "R7 address kept" : {tg, " address"}, memAddr, a);
        if (wr) chk(memWdata == d, intrude ? "R7 data kept" : "R2 write data", memWdata, d);
        chk(!done && busy, "R4 no early done", {done, busy}, 2'b01);
      end else begin
        chk(done && !memRd && !memWr, "R4 done timing", {done, memRd, memWr}, 3'b100);
        chk(!busy, "R6 idle with done", busy, 1'b0);
        if (!wr) chk(rdData == expRd, "R5 read data", rdData, expRd);
        got = rdData;
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R6 single done", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [DW-1:0] got;
    store[16'h2010] = 16'h00C4;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memRd && !memWr, "R1 reset state", {busy, done, memRd, memWr}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memRd && !memWr, "R1 after release", {busy, done, memRd, memWr}, 4'b0000);

    // R2 / R10 write of 0x7E to 0x2005
    access(1'b1, 16'h2005, 16'h007E, 3, 1'b0, '0, got);
    chk(peek(16'h2005) == 16'h007E, "R2 memory stored", peek(16'h2005), 16'h007E);

    // R10 read back
    access(1'b0, 16'h2005, '0, 5, 1'b0, 16'h007E, got);
    chk(got == 16'h007E, "R10 readback 0x2005", got, 16'h007E);

    // R3 / R10 read of preloaded 0x2010 with minimum latency
    access(1'b0, 16'h2010, '0, 1, 1'b0, 16'h00C4, got);
    chk(got == 16'h00C4, "R10 read 0x2010", got, 16'h00C4);

    // R5 read data held while idle
    repeat (3) @(negedge clk);
    chk(rdData == 16'h00C4, "R5 read data held", rdData, 16'h00C4);

    // R9 stray ready while idle
    strayReady = 1'b1;
    @(negedge clk);
    chk(!done && !busy, "R9 stray ready 1", {done, busy}, 2'b00);
    @(negedge clk);
    strayReady = 1'b0;
    chk(!done && !busy, "R9 stray ready 2", {done, busy}, 2'b00);
    @(negedge clk);
    chk(!done && !busy && rdData == 16'h00C4, "R9 no capture", rdData, 16'h00C4);

    // R7 intruding write while a read is running
    access(1'b0, 16'h2010, '0, 4, 1'b1, 16'h00C4, got);
    access(1'b0, 16'h3000, '0, 8, 1'b0, 16'h3000 ^ 16'h6C39, got);
    chk(got == (16'h3000 ^ 16'h6C39), "R7 intruder not written", got, 16'h3000 ^ 16'h6C39);

    // R4 long-latency write then short read
    access(1'b1, 16'h1234, 16'hA55A, 8, 1'b0, '0, got);
    access(1'b0, 16'h1234, '0, 2, 1'b0, 16'hA55A, got);
    chk(got == 16'hA55A, "R4 long write readback", got, 16'hA55A);

    finishRun();
  end

endmodule